// File: doc/BRIEF.md
# Programmable Bank Chip-Select and Wait-State Controller

This block sits between a bus master and a set of external memory or peripheral banks (SRAM, ROM, flash, simple peripherals). For each bus cycle it compares the address against every bank's programmed base and mask. It drives one chip-select line for the winning bank. After a programmed number of clocks it returns a two-bit data-size acknowledge, and that code tells the master how wide the selected port is. Writes to a protected bank are refused with a bus error, and a sticky status flag records them.

Each bank has two configuration words, a base word and an option word, written through a small configuration port. Bank 0 comes out of reset already valid, with a match-everything mask, so a boot ROM can be reached before any software setup. A bank can be marked for fast two-clock access. That option is honoured only when the on-chip master owns the bus. Cycles from an external master always take at least three clocks.

Top module: `bank_select_unit`

## Requirements
- R1: After reset, bank 0 is valid with a mask of zero, an 8-bit port and BOOT_WAIT (default 14) wait states. Any access before configuration asserts cs_o[0] and acknowledges with code 01 after 17 clocks. All other banks are invalid, and cs_o, dsack_o, berr_o and wp_err_o are 0.
- R2: Base word layout: bits [AW-1:8] are the base address, bit 1 is write protect and bit 0 is valid. Option word layout: bits [AW-1:8] are the mask, bits [7:4] the wait count, bits [3:2] the port size and bit 0 the fast-access enable. A bank hits when ((addr ^ base) & mask) is zero over bits [AW-1:8].
- R3: When several valid banks hit, the lowest-numbered one is selected. cs_o is never more than one-hot.
- R4: A bank whose valid bit is 0 never asserts its chip select. An access that hits no bank gives no chip select, no acknowledge and no bus error.
- R5: Port size codes are 01 = 8-bit, 10 = 16-bit, and 00 or 11 = 32-bit. The acknowledge is 11 for a 32-bit port, 10 for a 16-bit port and 01 for an 8-bit port.
- R6: A cycle lasts 3 + wait clocks, counting the clock in which the strobe is first presented as clock 1 and the first clock with the acknowledge visible as the last. A wait field of 15 is treated as 14.
- R7: A fast-enabled bank accessed by the internal master (ext_master_i = 0) completes in 2 clocks.
- R8: A cycle run by an external master (ext_master_i = 1) ignores the fast bit and takes 3 + wait clocks.
- R9: A write (wr_i = 1) to a write-protected bank asserts no chip select and no acknowledge. It asserts berr_o and sets wp_err_o. Reads of a protected bank proceed normally.
- R10: wp_err_o stays set across later cycles until stat_clr_i is pulsed high, which clears it.
- R11: cs_o, dsack_o and berr_o are all 0 in the clock after as_i is negated. The wait count restarts for every new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_bank_i | input | $clog2(NBANK) | Bank addressed by the configuration write |
| cfg_opt_i | input | 1 | 0 writes the base word, 1 writes the option word |
| cfg_data_i | input | AW | Configuration word |
| stat_clr_i | input | 1 | Pulse high to clear the protect-violation flag |
| as_i | input | 1 | Address strobe, high for the whole bus cycle |
| addr_i | input | AW | Cycle address |
| wr_i | input | 1 | 1 = write cycle, 0 = read cycle |
| ext_master_i | input | 1 | 1 when an external master owns the bus |
| cs_o | output | NBANK | One-hot chip selects |
| dsack_o | output | 2 | Data-size acknowledge code |
| berr_o | output | 1 | Bus error for a refused protected write |
| wp_err_o | output | 1 | Sticky write-protect violation flag |

## Verification
The bench builds the block with its defaults: four banks, a 32-bit address and a boot wait of 14. With these values the longest access, 17 clocks, is reached both through the boot bank and through a wait field of 15. Two overlapping banks exercise the priority rule. Every port-size code and both master types fall within a few dozen cycles. A protected bank with the fast bit set shows the internal/external split and write refusal on the same bank.

// File: rtl/csu_pkg.sv
package csu_pkg;

  typedef struct packed {
    logic       valid;
    logic       wprot;
    logic       fast;
    logic [1:0] psize;
    logic [3:0] waits;
  } bank_attr_t;

  localparam logic [1:0] PS_BYTE = 2'b01;
  localparam logic [1:0] PS_HALF = 2'b10;

  // Acknowledge code returned for a given port-size field.
  function automatic logic [1:0] ack_code(input logic [1:0] psize);
    case (psize)
      PS_BYTE: ack_code = 2'b01;
      PS_HALF: ack_code = 2'b10;
      default: ack_code = 2'b11;
    endcase
  endfunction

  // Total clocks of an access, from strobe to the first acknowledged clock.
  function automatic logic [4:0] access_len(input logic [3:0] waits,
                                            input logic fast,
                                            input logic ext);
    logic [3:0] w;
    w = (waits == 4'd15) ? 4'd14 : waits;
    if (fast && !ext) access_len = 5'd2;
    else              access_len = 5'd3 + {1'b0, w};
  endfunction

endpackage

// File: rtl/csu_regfile.sv
module csu_regfile
  import csu_pkg::*;
#(
  parameter int NBANK     = 4,
  parameter int AW        = 32,
  parameter int BOOT_WAIT = 14,
  localparam int IDXW     = $clog2(NBANK),
  localparam int HW       = AW - 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [IDXW-1:0] cfg_bank_i,
  input  logic            cfg_opt_i,
  input  logic [AW-1:0]   cfg_data_i,
  output logic [HW-1:0]   base_o [NBANK],
  output logic [HW-1:0]   mask_o [NBANK],
  output bank_attr_t      attr_o [NBANK]
);

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    localparam logic BOOT = (i == 0);
    logic sel;
    assign sel = cfg_we_i && (cfg_bank_i == IDXW'(i));

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        base_o[i]       <= '0;
        mask_o[i]       <= '0;
        attr_o[i].valid <= BOOT;
        attr_o[i].wprot <= 1'b0;
        attr_o[i].fast  <= 1'b0;
        attr_o[i].psize <= BOOT ? PS_BYTE : 2'b00;
        attr_o[i].waits <= BOOT ? 4'(BOOT_WAIT) : 4'd0;
      end else if (sel && !cfg_opt_i) begin
        base_o[i]       <= cfg_data_i[AW-1:8];
        attr_o[i].wprot <= cfg_data_i[1];
        attr_o[i].valid <= cfg_data_i[0];
      end else if (sel && cfg_opt_i) begin
        mask_o[i]       <= cfg_data_i[AW-1:8];
        attr_o[i].waits <= cfg_data_i[7:4];
        attr_o[i].psize <= cfg_data_i[3:2];
        attr_o[i].fast  <= cfg_data_i[0];
      end
    end
  end

endmodule

// File: rtl/csu_decode.sv
module csu_decode
  import csu_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int AW    = 32,
  localparam int IDXW = $clog2(NBANK),
  localparam int HW   = AW - 8
) (
  input  logic [AW-1:0]   addr_i,
  input  logic [HW-1:0]   base_i [NBANK],
  input  logic [HW-1:0]   mask_i [NBANK],
  input  bank_attr_t      attr_i [NBANK],
  output logic            any_hit_o,
  output logic [IDXW-1:0] win_idx_o,
  output bank_attr_t      win_attr_o
);

  logic [NBANK-1:0] hit;

  for (genvar i = 0; i < NBANK; i++) begin : g_cmp
    assign hit[i] = attr_i[i].valid &&
                    (((addr_i[AW-1:8] ^ base_i[i]) & mask_i[i]) == '0);
  end

  always_comb begin
    any_hit_o = 1'b0;
    win_idx_o = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any_hit_o = 1'b1;
        win_idx_o = IDXW'(i);
      end
    end
  end

  assign win_attr_o = attr_i[win_idx_o];

endmodule

// File: rtl/csu_cycle.sv
module csu_cycle
  import csu_pkg::*;
#(
  parameter int NBANK = 4,
  localparam int IDXW = $clog2(NBANK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             as_i,
  input  logic             wr_i,
  input  logic             ext_master_i,
  input  logic             stat_clr_i,
  input  logic             any_hit_i,
  input  logic [IDXW-1:0]  win_idx_i,
  input  bank_attr_t       win_attr_i,
  output logic             start_evt_o,
  output logic             wp_viol_evt_o,
  output logic [NBANK-1:0] cs_o,
  output logic [1:0]       dsack_o,
  output logic             berr_o,
  output logic             wp_err_o
);

  logic       busy_q;
  logic [3:0] cnt_q;
  logic [1:0] code_q;
  logic [4:0] len;
  logic       grant;

  assign start_evt_o   = as_i && !busy_q;
  assign wp_viol_evt_o = start_evt_o && any_hit_i && win_attr_i.wprot && wr_i;
  assign grant         = start_evt_o && any_hit_i && !wp_viol_evt_o;
  assign len           = access_len(win_attr_i.waits, win_attr_i.fast, ext_master_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      code_q  <= '0;
      cs_o    <= '0;
      dsack_o <= '0;
      berr_o  <= 1'b0;
    end else if (!as_i) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      cs_o    <= '0;
      dsack_o <= '0;
      berr_o  <= 1'b0;
    end else if (start_evt_o) begin
      busy_q <= 1'b1;
      berr_o <= wp_viol_evt_o;
      if (grant) begin
        cs_o    <= NBANK'(1) << win_idx_i;
        code_q  <= ack_code(win_attr_i.psize);
        cnt_q   <= 4'(len - 5'd2);
        dsack_o <= (len == 5'd2) ? ack_code(win_attr_i.psize) : 2'b00;
      end else begin
        code_q <= '0;
        cnt_q  <= '0;
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 4'd1;
      if (cnt_q == 4'd1) dsack_o <= code_q;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)            wp_err_o <= 1'b0;
    else if (wp_viol_evt_o) wp_err_o <= 1'b1;
    else if (stat_clr_i)    wp_err_o <= 1'b0;
  end

endmodule

// File: rtl/bank_select_unit.sv
module bank_select_unit
  import csu_pkg::*;
#(
  parameter int NBANK     = 4,
  parameter int AW        = 32,
  parameter int BOOT_WAIT = 14,
  localparam int IDXW     = $clog2(NBANK),
  localparam int HW       = AW - 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IDXW-1:0]  cfg_bank_i,
  input  logic             cfg_opt_i,
  input  logic [AW-1:0]    cfg_data_i,
  input  logic             stat_clr_i,
  input  logic             as_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_i,
  input  logic             ext_master_i,
  output logic [NBANK-1:0] cs_o,
  output logic [1:0]       dsack_o,
  output logic             berr_o,
  output logic             wp_err_o
);

  logic [HW-1:0]   base   [NBANK];
  logic [HW-1:0]   mask   [NBANK];
  bank_attr_t      attr   [NBANK];
  logic            any_hit;
  logic [IDXW-1:0] win_idx;
  bank_attr_t      win_attr;
  logic            start_evt;
  logic            wp_viol_evt;

  csu_regfile #(.NBANK(NBANK), .AW(AW), .BOOT_WAIT(BOOT_WAIT)) regs_i (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_bank_i, .cfg_opt_i, .cfg_data_i,
    .base_o(base), .mask_o(mask), .attr_o(attr)
  );

  csu_decode #(.NBANK(NBANK), .AW(AW)) dec_i (
    .addr_i, .base_i(base), .mask_i(mask), .attr_i(attr),
    .any_hit_o(any_hit), .win_idx_o(win_idx), .win_attr_o(win_attr)
  );

  csu_cycle #(.NBANK(NBANK)) cyc_i (
    .clk_i, .rst_ni, .as_i, .wr_i, .ext_master_i, .stat_clr_i,
    .any_hit_i(any_hit), .win_idx_i(win_idx), .win_attr_i(win_attr),
    .start_evt_o(start_evt), .wp_viol_evt_o(wp_viol_evt),
    .cs_o, .dsack_o, .berr_o, .wp_err_o
  );

endmodule

// File: rtl/csu_checker.sv
module csu_checker #(
  parameter int NBANK = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             as_i,
  input logic             ext_master_i,
  input logic             stat_clr_i,
  input logic             start_evt,
  input logic             wp_viol_evt,
  input logic [NBANK-1:0] cs_o,
  input logic [1:0]       dsack_o,
  input logic             berr_o,
  input logic             wp_err_o
);

  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o)); // R3

  AST_ACK_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsack_o != 2'b00) |-> (cs_o != '0)); // R4

  AST_EXT_NOT_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_evt && ext_master_i) |=> (dsack_o == 2'b00)); // R8

  AST_WP_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_viol_evt |=> (berr_o && cs_o == '0 && dsack_o == 2'b00 && wp_err_o)); // R9

  AST_WP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_err_o && !stat_clr_i) |=> wp_err_o); // R10

  AST_STROBE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_i |=> (cs_o == '0 && dsack_o == 2'b00 && !berr_o)); // R11

  AST_BERR_ACK_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(berr_o && dsack_o != 2'b00)); // R9

endmodule

bind bank_select_unit csu_checker #(.NBANK(NBANK)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .as_i(as_i), .ext_master_i(ext_master_i),
  .stat_clr_i(stat_clr_i), .start_evt(start_evt), .wp_viol_evt(wp_viol_evt),
  .cs_o(cs_o), .dsack_o(dsack_o), .berr_o(berr_o), .wp_err_o(wp_err_o)
);

// File: tb/bank_select_unit_tb.sv
module bank_select_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NBANK = 4;
  localparam int AW    = 32;

  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic        ext;
    logic [3:0]  cs;
    logic [1:0]  ack;
    logic        berr;
    logic [4:0]  len;
  } vec_t;

  // Bank map (see R2, R5): b0 8-bit wait 2; b1 16-bit fast, protected;
  // b2 32-bit wait field 15; b3 32-bit wait 3 overlapping b2.
  localparam int NVEC = 9;
  localparam vec_t VEC [NVEC] = '{
    '{32'h0000_1234, 1'b0, 1'b0, 4'b0001, 2'b01, 1'b0, 5'd5},   // R2 R5 R6
    '{32'h0000_1234, 1'b1, 1'b1, 4'b0001, 2'b01, 1'b0, 5'd5},   // R11 reload
    '{32'h1000_0000, 1'b0, 1'b0, 4'b0010, 2'b10, 1'b0, 5'd2},   // R7
    '{32'h1000_0000, 1'b0, 1'b1, 4'b0010, 2'b10, 1'b0, 5'd3},   // R8
    '{32'h1080_0000, 1'b0, 1'b0, 4'b0010, 2'b10, 1'b0, 5'd2},   // R2 mask
    '{32'h2000_0040, 1'b0, 1'b0, 4'b0100, 2'b11, 1'b0, 5'd17},  // R3 R6 clamp
    '{32'h2010_0000, 1'b1, 1'b0, 4'b1000, 2'b11, 1'b0, 5'd6},   // R2 R5
    '{32'h3000_0000, 1'b0, 1'b0, 4'b0000, 2'b00, 1'b0, 5'd0},   // R4 no hit
    '{32'h1000_0010, 1'b1, 1'b0, 4'b0000, 2'b00, 1'b1, 5'd0}    // R9
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_we_i = 1'b0;
  logic [1:0]       cfg_bank_i = '0;
  logic             cfg_opt_i = 1'b0;
  logic [AW-1:0]    cfg_data_i = '0;
  logic             stat_clr_i = 1'b0;
  logic             as_i = 1'b0;
  logic [AW-1:0]    addr_i = '0;
  logic             wr_i = 1'b0;
  logic             ext_master_i = 1'b0;
  logic [NBANK-1:0] cs_o;
  logic [1:0]       dsack_o;
  logic             berr_o;
  logic             wp_err_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bank_select_unit #(.NBANK(NBANK), .AW(AW), .BOOT_WAIT(14)) dut_i (.*);

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input int bank, input logic opt, input logic [31:0] data);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_bank_i = 2'(bank); cfg_opt_i = opt; cfg_data_i = data;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // Runs one strobe cycle; len = clocks to acknowledge (0 if none in 24).
  task automatic bus_cycle(input logic [31:0] a, input logic w, input logic e,
                           output logic [3:0] cs_seen, output logic [1:0] ack,
                           output logic be, output logic [4:0] len);
    cs_seen = '0; ack = '0; be = 1'b0; len = '0;
    @(negedge clk_i);
    addr_i = a; wr_i = w; ext_master_i = e; as_i = 1'b1;
    for (int k = 1; k <= 24; k++) begin
      @(negedge clk_i);
      cs_seen |= cs_o;
      be |= berr_o;
      if (dsack_o != 2'b00) begin
        len = 5'(k + 1);
        ack = dsack_o;
        break;
      end
    end
    as_i = 1'b0;
    @(negedge clk_i);
    check("R11", "idle after strobe", {cs_o, dsack_o, berr_o}, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] cs_v;
    logic [1:0] ack_v;
    logic       be_v;
    logic [4:0] len_v;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "reset outputs", {cs_o, dsack_o, berr_o, wp_err_o}, '0);

    bus_cycle(32'hABCD_0000, 1'b0, 1'b0, cs_v, ack_v, be_v, len_v);
    check("R1", "boot cs", cs_v, 4'b0001);
    check("R1", "boot ack", ack_v, 2'b01);
    check("R1", "boot length", len_v, 5'd17);

    cfg(0, 1'b0, 32'h0000_0001);
    cfg(0, 1'b1, 32'hFFFF_0024);
    cfg(1, 1'b0, 32'h1000_0003);
    cfg(1, 1'b1, 32'hFF00_0009);
    cfg(2, 1'b0, 32'h2000_0001);
    cfg(2, 1'b1, 32'hFFF0_00F0);
    cfg(3, 1'b0, 32'h2000_0001);
    cfg(3, 1'b1, 32'hFF00_0030);

    for (int v = 0; v < NVEC; v++) begin
      bus_cycle(VEC[v].addr, VEC[v].wr, VEC[v].ext, cs_v, ack_v, be_v, len_v);
      check("R2-vec", $sformatf("v%0d cs", v), cs_v, VEC[v].cs);
      check("R5-vec", $sformatf("v%0d ack", v), ack_v, VEC[v].ack);
      check("R9-vec", $sformatf("v%0d berr", v), be_v, VEC[v].berr);
      check("R6-vec", $sformatf("v%0d len", v), len_v, VEC[v].len);
    end

    // R9: protected write flagged; R10: flag sticks across other cycles
    check("R9", "status set", wp_err_o, 1'b1);
    bus_cycle(32'h0000_0000, 1'b0, 1'b0, cs_v, ack_v, be_v, len_v);
    repeat (5) @(negedge clk_i);
    check("R10", "status sticky", wp_err_o, 1'b1);
    stat_clr_i = 1'b1;
    @(negedge clk_i);
    stat_clr_i = 1'b0;
    check("R10", "status cleared", wp_err_o, 1'b0);

    // R9: external protected write also refused
    bus_cycle(32'h1000_0000, 1'b1, 1'b1, cs_v, ack_v, be_v, len_v);
    check("R9", "ext wp cs", cs_v, 4'b0000);
    check("R9", "ext wp berr", be_v, 1'b1);
    check("R9", "ext wp status", wp_err_o, 1'b1);

    // R4: invalidated bank never selects
    cfg(3, 1'b0, 32'h2000_0000);
    bus_cycle(32'h2010_0000, 1'b0, 1'b0, cs_v, ack_v, be_v, len_v);
    check("R4", "invalid bank cs", cs_v, 4'b0000);
    check("R4", "invalid bank ack", ack_v, 2'b00);
    check("R4", "invalid bank berr", be_v, 1'b0);

    // R3: bank 2 alone still serves its range after bank 3 is gone
    bus_cycle(32'h2000_0040, 1'b0, 1'b1, cs_v, ack_v, be_v, len_v);
    check("R3", "bank2 cs", cs_v, 4'b0100);
    check("R8", "ext bank2 length", len_v, 5'd17);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule